// File: doc/BRIEF.md
# Serial Receiver with Line-Break Detection

This block receives asynchronous serial characters on one data line. It samples the line with an enable pulse that runs at sixteen times the bit rate. Before sampling, the line passes through a two-stage synchronizer. Character length is selectable from five to eight bits, and an optional even or odd parity bit may follow the data. Each finished character goes into an eight-entry receive queue. Every entry carries three flags of its own: line break, framing error and parity error.

A break is a frame in which every data bit, the parity bit (when enabled) and the stop bit are all low. A break takes one queue entry. After that, the receiver writes nothing more until the line has stayed high for half a bit time. A sticky break-change flag is set when a break is found and set again when it ends. Host command strobes clear the overrun flag and the break-change flag. An 8-bit status word shows the flags of the entry at the head of the queue, together with the overrun, full and data-ready bits.

Top module: `uart_rx_brk`

## Requirements
- R1: A start bit is accepted only if the synchronized line is still low at the eighth sample tick after the falling edge is seen; a low pulse shorter than half a bit time leaves the queue empty.
- R2: Data bits are sampled at mid-bit and stored least significant bit first. The length code `char_len` gives 5 + code bits (0 to 3), and the unused upper bits read as zero.
- R3: When `par_en` is 1, one parity bit follows the data. The parity is even when `par_odd` is 0 and odd when it is 1. A mismatch sets the entry's parity flag. Break entries never carry it.
- R4: The stop bit is sampled at the middle of its bit time. If it is low in a frame that is not a break, the entry's framing flag is set and the data is kept.
- R5: A frame with all data bits, the parity bit (if enabled) and the stop bit low is stored as exactly one entry, with data 0x00, the break flag set, and the framing and parity flags clear.
- R6: After a break entry, no entry is written until the line has been high for 8 consecutive sample ticks. A shorter high period restarts that count.
- R7: `brk_change` is set when a break is stored and set again when the break ends. It stays set until `cmd_reset_brk` is strobed. A set in the same cycle wins over the clear.
- R8: A break that begins partway through a character first yields an ordinary entry for that character, and a break entry follows only if the line stays low through the whole next character.
- R9: Status layout: bit 7 break, bit 6 framing, bit 5 parity (all three for the head entry, zero when the queue is empty), bit 4 overrun, bits 3 and 2 always 0, bit 1 queue full (8 entries), bit 0 data ready (at least 1 entry).
- R10: A character that finishes while the queue holds 8 entries sets overrun and is discarded. The stored entries are unchanged.
- R11: `cmd_reset_err` clears the overrun bit.
- R12: After reset the status word is 0x00 and `brk_change` is 0.
- R13: `pop` with an empty queue has no effect; the next received character becomes the head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Sample enable at 16x bit rate |
| rxd | input | 1 | Serial data line, idle high |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity |
| pop | input | 1 | Remove the head entry |
| cmd_reset_err | input | 1 | Clear overrun |
| cmd_reset_brk | input | 1 | Clear break-change flag |
| rd_data | output | 8 | Data of the head entry |
| status | output | 8 | Status word |
| brk_change | output | 1 | Break start/end event flag |

## Verification
The hardest case to reach from the ports is a break that starts partway through a character, together with the lockout that follows it. The line must drop after a few data bits and stay low through the rest of that frame and the whole next one. Directed sequences hold the line low over exactly those windows and then check both entries. Further directed sequences insert short high glitches during the lockout and clear `brk_change` while the line is still low, so that only the true end of the break can set it again. Random frames with random lengths, parity modes, parity corruption and stop-bit faults exercise the ordinary path.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       brk;
        logic       fe;
        logic       pe;
    } rx_entry_t;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      os_tick,
    input  logic      rxd,
    input  logic [1:0] char_len,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      push,
    output rx_entry_t entry,
    output logic      brk_start,
    output logic      brk_end,
    output logic      lockout
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    bidx;
        logic [7:0]    data;
        logic          par_bit;
    } smp_t;

    smp_t s_d, s_q;
    logic       rx;
    logic [3:0] nbits;
    logic       is_brk;

    assign rx    = s_q.sync[1];
    assign nbits = 4'd5 + {2'b00, char_len};

    always_comb begin
        s_d       = s_q;
        push      = 1'b0;
        entry     = '0;
        brk_start = 1'b0;
        brk_end   = 1'b0;
        is_brk    = 1'b0;
        s_d.sync  = {s_q.sync[0], rxd};
        if (os_tick) begin
            unique case (s_q.st)
                RX_IDLE: begin
                    if (!rx) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.cnt == MID) begin
                        s_d.cnt = '0;
                        if (!rx) begin
                            s_d.st      = RX_DATA;
                            s_d.bidx    = '0;
                            s_d.data    = '0;
                            s_d.par_bit = 1'b0;
                        end else begin
                            s_d.st = RX_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt             = '0;
                        s_d.data[s_q.bidx]  = rx;
                        if ({1'b0, s_q.bidx} == nbits - 4'd1) begin
                            s_d.st = par_en ? RX_PAR : RX_STOP;
                        end else begin
                            s_d.bidx = s_q.bidx + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt     = '0;
                        s_d.par_bit = rx;
                        s_d.st      = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.cnt == LAST) begin
                        is_brk     = (s_q.data == 8'h00) && !s_q.par_bit && !rx;
                        push       = 1'b1;
                        entry.data = s_q.data;
                        entry.brk  = is_brk;
                        entry.fe   = !rx && !is_brk;
                        entry.pe   = par_en && !is_brk && (^{s_q.data, s_q.par_bit, par_odd});
                        s_d.cnt    = '0;
                        if (is_brk) begin
                            brk_start = 1'b1;
                            s_d.st    = RX_BRKWAIT;
                        end else begin
                            s_d.st = RX_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_BRKWAIT: begin
                    if (rx) begin
                        if (s_q.cnt == MID) begin
                            brk_end = 1'b1;
                            s_d.cnt = '0;
                            s_d.st  = RX_IDLE;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else begin
                        s_d.cnt = '0;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    assign lockout = (s_q.st == RX_BRKWAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
            s_q.st   <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t dout,
    output logic      empty,
    output logic      full
);
    localparam int PW = $clog2(DEPTH);
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
    localparam logic [NW-1:0] NFULL = NW'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [NW-1:0]         cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    assign empty   = (f_q.cnt == '0);
    assign full    = (f_q.cnt == NFULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = f_q.mem[f_q.rp];

    always_comb begin
        f_d = f_q;
        if (do_push) begin
            f_d.mem[f_q.wp] = din;
            f_d.wp          = (f_q.wp == PLAST) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == PLAST) ? '0 : f_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       pop,
    input  logic       cmd_reset_err,
    input  logic       cmd_reset_brk,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       brk_change
);
    typedef struct packed {
        logic ovr;
        logic bchg;
    } flags_t;

    flags_t    r_d, r_q;
    logic      smp_push, brk_start, brk_end, lockout, brk_evt;
    rx_entry_t smp_entry, head;
    logic      q_empty, q_full;

    rx_sampler #(.OSR(OSR)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .char_len  (char_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .push      (smp_push),
        .entry     (smp_entry),
        .brk_start (brk_start),
        .brk_end   (brk_end),
        .lockout   (lockout)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (smp_push),
        .din   (smp_entry),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign brk_evt = brk_start || brk_end;

    always_comb begin
        r_d = r_q;
        if (cmd_reset_err)      r_d.ovr  = 1'b0;
        if (smp_push && q_full) r_d.ovr  = 1'b1;
        if (cmd_reset_brk)      r_d.bchg = 1'b0;
        if (brk_evt)            r_d.bchg = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data    = head.data;
    assign brk_change = r_q.bchg;
    assign status     = {head.brk && !q_empty, head.fe && !q_empty, head.pe && !q_empty,
                         r_q.ovr, 2'b00, q_full, !q_empty};
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pop,
    input logic       cmd_reset_err,
    input logic       cmd_reset_brk,
    input logic [7:0] status,
    input logic       brk_change,
    input logic       smp_push,
    input logic       lockout,
    input logic       brk_evt
);
    assert_full_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]);

    assert_no_push_in_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !smp_push);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !cmd_reset_err) |=> status[4]);

    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_push && status[1]) |=> status[4]);

    assert_overrun_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset_err && !(smp_push && status[1])) |=> !status[4]);

    assert_brkchg_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk_change);

    assert_brkchg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset_brk && !brk_evt) |=> !brk_change);

    assert_empty_only_by_pop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> $past(pop));
endmodule

bind uart_rx_brk uart_rx_brk_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pop           (pop),
    .cmd_reset_err (cmd_reset_err),
    .cmd_reset_brk (cmd_reset_brk),
    .status        (status),
    .brk_change    (brk_change),
    .smp_push      (smp_push),
    .lockout       (lockout),
    .brk_evt       (brk_evt)
);

// File: tb/uart_rx_brk_tb_top.sv
module uart_rx_brk_tb_top;
    localparam int BIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       pop = 1'b0;
    logic       cmd_reset_err = 1'b0;
    logic       cmd_reset_brk = 1'b0;
    logic [7:0] rd_data, status;
    logic       brk_change;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_brk dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .pop(pop), .cmd_reset_err(cmd_reset_err), .cmd_reset_brk(cmd_reset_brk),
        .rd_data(rd_data), .status(status), .brk_change(brk_change)
    );

    function automatic logic [7:0] len_mask(input logic [1:0] code);
        return 8'hFF >> (3 - code);
    endfunction

    function automatic logic par_bit_of(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic line(input logic b, input int cycles);
        rxd = b;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic flip_par, input logic stopv);
        logic [7:0] dm;
        dm = d & len_mask(char_len);
        line(1'b0, BIT);
        for (int i = 0; i < 5 + int'(char_len); i++) line(dm[i], BIT);
        if (par_en) line(par_bit_of(dm, par_odd) ^ flip_par, BIT);
        line(stopv, BIT);
        line(1'b1, BIT);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_entry(input logic [7:0] d, input logic b, input logic f, input logic p, input string req);
        chk(status[0] == 1'b1, {req, " ready"}, {31'd0, status[0]}, 32'd1);
        chk(rd_data == d, {req, " data"}, {24'd0, rd_data}, {24'd0, d});
        chk(status[7:5] == {b, f, p}, {req, " flags"}, {29'd0, status[7:5]}, {29'd0, b, f, p});
        do_pop();
    endtask

    task automatic pulse_brk_clear();
        cmd_reset_brk = 1'b1;
        @(negedge clk);
        cmd_reset_brk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(status == 8'h00, "R12 status", {24'd0, status}, 32'd0);
        chk(brk_change == 1'b0, "R12 brk_change", {31'd0, brk_change}, 32'd0);

        // R1 short low glitch is not a start bit
        line(1'b0, 5);
        line(1'b1, 40);
        chk(status[0] == 1'b0, "R1 glitch ignored", {31'd0, status[0]}, 32'd0);

        // R2 eight and five bit characters
        char_len = 2'd3; send_char(8'hA5, 1'b0, 1'b1);
        expect_entry(8'hA5, 1'b0, 1'b0, 1'b0, "R2 8-bit");
        char_len = 2'd0; send_char(8'hFB, 1'b0, 1'b1);
        expect_entry(8'h1B, 1'b0, 1'b0, 1'b0, "R2 5-bit");

        // R3 parity even/odd, good and corrupted
        char_len = 2'd2; par_en = 1'b1; par_odd = 1'b0;
        send_char(8'h55, 1'b1, 1'b1);
        expect_entry(8'h55, 1'b0, 1'b0, 1'b1, "R3 even bad");
        par_odd = 1'b1;
        send_char(8'h13, 1'b0, 1'b1);
        expect_entry(8'h13, 1'b0, 1'b0, 1'b0, "R3 odd good");
        par_en = 1'b0; char_len = 2'd3;

        // R4 framing error
        send_char(8'h3C, 1'b0, 1'b0);
        expect_entry(8'h3C, 1'b0, 1'b1, 1'b0, "R4 framing");

        // Random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d, dm;
            logic flip, stopv, pb;
            char_len = 2'($urandom_range(0, 3));
            par_en   = 1'($urandom_range(0, 1));
            par_odd  = 1'($urandom_range(0, 1));
            d        = 8'($urandom_range(0, 255));
            flip     = par_en && ($urandom_range(0, 3) == 0);
            stopv    = ($urandom_range(0, 4) != 0);
            dm       = d & len_mask(char_len);
            pb       = par_en ? (par_bit_of(dm, par_odd) ^ flip) : 1'b0;
            if (dm == 8'h00 && !pb) stopv = 1'b1;
            send_char(d, flip, stopv);
            expect_entry(dm, 1'b0, !stopv, flip, "R2 R3 R4 random");
        end
        char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;

        // R5 R6 R7 break with lockout, clear while low, glitch during lockout
        line(1'b0, BIT * 12);
        chk(brk_change == 1'b1, "R7 set on break", {31'd0, brk_change}, 32'd1);
        pulse_brk_clear();
        line(1'b0, BIT * 20);
        chk(brk_change == 1'b0, "R7 cleared while low", {31'd0, brk_change}, 32'd0);
        line(1'b1, 4);
        line(1'b0, 40);
        chk(brk_change == 1'b0, "R6 glitch does not end break", {31'd0, brk_change}, 32'd0);
        line(1'b1, 30);
        chk(brk_change == 1'b1, "R7 set on break end", {31'd0, brk_change}, 32'd1);
        expect_entry(8'h00, 1'b1, 1'b0, 1'b0, "R5 break entry");
        chk(status[0] == 1'b0, "R6 single entry", {31'd0, status[0]}, 32'd0);
        pulse_brk_clear();
        send_char(8'h81, 1'b0, 1'b1);
        expect_entry(8'h81, 1'b0, 1'b0, 1'b0, "R6 reception resumes");

        // R8 break starting mid-character
        line(1'b0, BIT);
        line(1'b1, BIT * 3);
        line(1'b0, BIT * 6 + BIT * 10 + 32);
        line(1'b1, 40);
        expect_entry(8'h07, 1'b0, 1'b1, 1'b0, "R8 cut character");
        expect_entry(8'h00, 1'b1, 1'b0, 1'b0, "R8 break entry");
        chk(brk_change == 1'b1, "R8 brk_change", {31'd0, brk_change}, 32'd1);
        pulse_brk_clear();

        // R9 R10 fill queue and overrun
        for (int i = 0; i < 8; i++) send_char(8'h30 + 8'(i), 1'b0, 1'b1);
        chk(status == 8'h03, "R9 full status", {24'd0, status}, 32'h03);
        send_char(8'hEE, 1'b0, 1'b1);
        chk(status[4] == 1'b1, "R10 overrun set", {31'd0, status[4]}, 32'd1);
        for (int i = 0; i < 8; i++)
            expect_entry(8'h30 + 8'(i), 1'b0, 1'b0, 1'b0, "R10 contents kept");
        chk(status == 8'h10, "R9 empty with overrun", {24'd0, status}, 32'h10);

        // R11 clear overrun
        cmd_reset_err = 1'b1;
        @(negedge clk);
        cmd_reset_err = 1'b0;
        @(negedge clk);
        chk(status[4] == 1'b0, "R11 overrun cleared", {31'd0, status[4]}, 32'd0);

        // R13 pop on empty
        do_pop();
        chk(status == 8'h00, "R13 pop on empty", {24'd0, status}, 32'd0);
        send_char(8'h6D, 1'b0, 1'b1);
        expect_entry(8'h6D, 1'b0, 1'b0, 1'b0, "R13 next head");
        chk(status[0] == 1'b0, "R13 empty after pop", {31'd0, status[0]}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule